// File: doc/BRIEF.md
# Dual-Capture Compare Timer Unit

A 16-bit free-running counter with a byte-wide register port. The counter steps once for each cycle in which `tick` is high. Two capture channels copy the counter into their own 16-bit registers on a chosen edge of their inputs. One compare channel watches for the counter arriving at a programmed value. When that happens it loads a chosen level into an output latch. A counter wrap raises an overflow flag.

Capture channel 1 and the compare output share one device pin. A mode bit in the control register decides which of the two owns it. When the pin drives the compare latch, capture-1 edge detection is switched off. Switching the mode never sets or clears a flag.

Each event flag clears in two steps. First, read the status register while the flag is set. Then access that flag's own data register. If a fresh event arrives between the two steps, the flag stays set. A single interrupt line combines every flag with its enable.

Top module: `dcct_timer`

## Requirements
- R1: After reset, control (address 0) and status (address 1) both read 0x00. The output latch is low, `pin_oe` and `pin_out` are 0, and `irq` is 0.
- R2: The counter steps once per cycle with `tick` high and wraps from 0xFFFF to 0x0000. Its high byte reads at address 2 and its low byte at address 3. The wrap sets status bit 5 (overflow).
- R3: The compare register has its high byte at address 4 and its low byte at address 5. A match occurs on the tick that loads the counter with the compare value. A match sets status bit 4 and, at the same clock edge, loads control bit 0 into the output latch.
- R4: Control bit 3 set: `pin_oe` is 1, `pin_out` follows the latch, and edges on `pin_in` start no capture. Control bit 3 clear: `pin_oe` and `pin_out` are 0, and `pin_in` feeds capture channel 1.
- R5: Control bit 3 never blocks or clears a flag. The compare flag sets in either mode. A set capture-1 flag survives a mode change.
- R6: Control bit 2 picks the capture-1 edge and control bit 1 picks the capture-2 edge. A value of 1 selects rising and 0 selects falling. An edge of the other kind leaves flags and capture registers unchanged.
- R7: On a selected edge, the counter value is captured and the channel's flag sets. Channel 1 uses addresses 6 (high) and 7 (low) and status bit 6. Channel 2 uses addresses 8 and 9 and status bit 7. Each input passes through two synchronizer flops, so the capture happens on the third clock edge after the input changes. Status bits 3..0 read 0.
- R8: A flag clears only when a status read that sees it set is followed by its own access. Overflow clears on a read or write of address 3. Compare clears only on a write of address 5. Each capture flag clears on a read of its low byte. The access alone, without the prior status read, leaves the flag set.
- R9: If a flag's event recurs after the status read, the following data access leaves the flag set. A fresh status read is then needed before the access clears it.
- R10: `irq` is the OR of status bits 7..4, each ANDed with control bit 7..4 in the same position. It rises in the same cycle the flag becomes visible.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| tick | input | 1 | Counter advance enable |
| bus_addr | input | 4 | Register address |
| bus_rd | input | 1 | Read strobe, one cycle per access |
| bus_wr | input | 1 | Write strobe, one cycle per access |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data for `bus_addr` |
| pin_in | input | 1 | Shared pin as seen from outside; capture-1 source |
| pin_out | output | 1 | Compare latch toward the shared pin |
| pin_oe | output | 1 | Drive enable for the shared pin |
| cap2_in | input | 1 | Capture-2 source |
| irq | output | 1 | Combined interrupt request |

## Verification
The compare channel is tried with the interrupt enabled and masked, and in both pin modes. This separates flag setting from pin ownership and from interrupt gating.

Each capture channel is given rising and falling edges under both edge selects. This shows that only the chosen edge captures, and that pin mode gates channel 1 alone.

The flag-clearing sequences cover several orderings: the data access with no prior status read, a read where only a write should clear, and an event that recurs between the two steps. Each ordering must give a different status result.

A full counter wrap shows the overflow flag, its interrupt, and its clear through the counter low byte.

// File: rtl/dcct_pkg.sv
package dcct_pkg;

    localparam int BYTE_W  = 8;
    localparam int ADDR_W  = 4;
    localparam int CNT_W   = 2 * BYTE_W;
    localparam int N_FLAGS = 4;

    // flag indices; status and enable positions are these plus N_FLAGS
    localparam int F_CMP  = 0;
    localparam int F_OVF  = 1;
    localparam int F_CAP1 = 2;
    localparam int F_CAP2 = 3;

    localparam logic [ADDR_W-1:0] A_CTRL    = 4'd0;
    localparam logic [ADDR_W-1:0] A_STAT    = 4'd1;
    localparam logic [ADDR_W-1:0] A_CNT_HI  = 4'd2;
    localparam logic [ADDR_W-1:0] A_CNT_LO  = 4'd3;
    localparam logic [ADDR_W-1:0] A_CMP_HI  = 4'd4;
    localparam logic [ADDR_W-1:0] A_CMP_LO  = 4'd5;
    localparam logic [ADDR_W-1:0] A_CAP1_HI = 4'd6;
    localparam logic [ADDR_W-1:0] A_CAP1_LO = 4'd7;
    localparam logic [ADDR_W-1:0] A_CAP2_HI = 4'd8;
    localparam logic [ADDR_W-1:0] A_CAP2_LO = 4'd9;

    typedef struct packed {
        logic ie_cap2;
        logic ie_cap1;
        logic ie_ovf;
        logic ie_cmp;
        logic pin_cmp;   // 1: compare latch owns the shared pin
        logic edge1;     // 1: rising edge for capture 1
        logic edge2;     // 1: rising edge for capture 2
        logic olvl;      // level loaded into latch on match
    } ctrl_t;

    function automatic logic [BYTE_W-1:0] pick_byte(input logic [CNT_W-1:0] v,
                                                    input logic hi);
        return hi ? v[CNT_W-1:BYTE_W] : v[BYTE_W-1:0];
    endfunction

endpackage

// File: rtl/dcct_flag.sv
module dcct_flag (
    input  logic clk,
    input  logic rst,
    input  logic set_ev,
    input  logic stat_rd,
    input  logic clr_acc,
    output logic flag_q
);
    logic arm_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            flag_q <= 1'b0;
            arm_q  <= 1'b0;
        end else begin
            if (set_ev)
                flag_q <= 1'b1;
            else if (arm_q && clr_acc)
                flag_q <= 1'b0;

            // a new event voids an earlier status read
            if (set_ev)
                arm_q <= 1'b0;
            else if (stat_rd)
                arm_q <= flag_q;
            else if (clr_acc)
                arm_q <= 1'b0;
        end
    end

    a_r9_set_wins: assert property (@(posedge clk) disable iff (rst)
        set_ev |=> flag_q);

    a_r8_two_step_clear: assert property (@(posedge clk) disable iff (rst)
        (arm_q && clr_acc && !set_ev) |=> !flag_q);

    a_r8_no_clear_unarmed: assert property (@(posedge clk) disable iff (rst)
        (flag_q && !arm_q && !stat_rd) |=> flag_q);

endmodule

// File: rtl/dcct_capture.sv
module dcct_capture #(
    parameter int CNT_W       = 16,
    parameter int SYNC_STAGES = 2
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             sig_in,
    input  logic             rise_sel,
    input  logic             enable,
    input  logic [CNT_W-1:0] cnt_in,
    output logic             evt,
    output logic [CNT_W-1:0] cap_q
);
    localparam int LAST = SYNC_STAGES - 1;

    logic [LAST:0] sync_q;
    logic          prev_q;
    logic          rise, fall;

    generate
        if (SYNC_STAGES > 1) begin : g_chain
            always_ff @(posedge clk) begin
                if (rst) sync_q <= '0;
                else     sync_q <= {sync_q[LAST-1:0], sig_in};
            end
        end else begin : g_single
            always_ff @(posedge clk) begin
                if (rst) sync_q <= '0;
                else     sync_q <= sig_in;
            end
        end
    endgenerate

    assign rise = sync_q[LAST] & ~prev_q;
    assign fall = ~sync_q[LAST] & prev_q;
    assign evt  = enable & (rise_sel ? rise : fall);

    always_ff @(posedge clk) begin
        if (rst) begin
            prev_q <= 1'b0;
            cap_q  <= '0;
        end else begin
            prev_q <= sync_q[LAST];
            if (evt) cap_q <= cnt_in;
        end
    end

    a_r7_capture_value: assert property (@(posedge clk) disable iff (rst)
        evt |=> cap_q == $past(cnt_in));

    a_r6_hold_no_edge: assert property (@(posedge clk) disable iff (rst)
        !evt |=> $stable(cap_q));

endmodule

// File: rtl/dcct_timer.sv
module dcct_timer
    import dcct_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              tick,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic              bus_rd,
    input  logic              bus_wr,
    input  logic [BYTE_W-1:0] bus_wdata,
    output logic [BYTE_W-1:0] bus_rdata,
    input  logic              pin_in,
    output logic              pin_out,
    output logic              pin_oe,
    input  logic              cap2_in,
    output logic              irq
);
    ctrl_t              ctrl_q;
    logic [CNT_W-1:0]   cnt_q, cnt_nxt, cmp_q;
    logic               out_latch;
    logic               wrap_ev, cmp_ev;
    logic [1:0]         cap_evt;
    logic [CNT_W-1:0]   cap_val [2];
    logic [N_FLAGS-1:0] set_vec, clr_vec, flags, ie_vec;
    logic               stat_rd;

    assign cnt_nxt = cnt_q + 1'b1;
    assign wrap_ev = tick && (cnt_q == '1);
    assign cmp_ev  = tick && (cnt_nxt == cmp_q);

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt_q     <= '0;
            cmp_q     <= '1;
            ctrl_q    <= '0;
            out_latch <= 1'b0;
        end else begin
            if (tick) cnt_q <= cnt_nxt;
            if (cmp_ev) out_latch <= ctrl_q.olvl;
            if (bus_wr) begin
                case (bus_addr)
                    A_CTRL:   ctrl_q <= ctrl_t'(bus_wdata);
                    A_CMP_HI: cmp_q[CNT_W-1:BYTE_W] <= bus_wdata;
                    A_CMP_LO: cmp_q[BYTE_W-1:0]     <= bus_wdata;
                    default:  ;
                endcase
            end
        end
    end

    // capture channels: index 0 shares the pin, index 1 is dedicated
    generate
        for (genvar c = 0; c < 2; c++) begin : g_cap
            dcct_capture #(.CNT_W(CNT_W), .SYNC_STAGES(2)) u_cap (
                .clk      (clk),
                .rst      (rst),
                .sig_in   ((c == 0) ? pin_in : cap2_in),
                .rise_sel ((c == 0) ? ctrl_q.edge1 : ctrl_q.edge2),
                .enable   ((c == 0) ? ~ctrl_q.pin_cmp : 1'b1),
                .cnt_in   (cnt_q),
                .evt      (cap_evt[c]),
                .cap_q    (cap_val[c])
            );
        end
    endgenerate

    assign stat_rd = bus_rd && (bus_addr == A_STAT);

    always_comb begin
        set_vec         = '0;
        clr_vec         = '0;
        set_vec[F_CMP]  = cmp_ev;
        set_vec[F_OVF]  = wrap_ev;
        set_vec[F_CAP1] = cap_evt[0];
        set_vec[F_CAP2] = cap_evt[1];
        clr_vec[F_CMP]  = bus_wr && (bus_addr == A_CMP_LO);
        clr_vec[F_OVF]  = (bus_rd || bus_wr) && (bus_addr == A_CNT_LO);
        clr_vec[F_CAP1] = bus_rd && (bus_addr == A_CAP1_LO);
        clr_vec[F_CAP2] = bus_rd && (bus_addr == A_CAP2_LO);
    end

    generate
        for (genvar f = 0; f < N_FLAGS; f++) begin : g_flag
            dcct_flag u_flag (
                .clk     (clk),
                .rst     (rst),
                .set_ev  (set_vec[f]),
                .stat_rd (stat_rd),
                .clr_acc (clr_vec[f]),
                .flag_q  (flags[f])
            );
        end
    endgenerate

    assign ie_vec = {ctrl_q.ie_cap2, ctrl_q.ie_cap1, ctrl_q.ie_ovf, ctrl_q.ie_cmp};
    assign irq    = |(flags & ie_vec);

    assign pin_oe  = ctrl_q.pin_cmp;
    assign pin_out = ctrl_q.pin_cmp & out_latch;

    always_comb begin
        case (bus_addr)
            A_CTRL:    bus_rdata = ctrl_q;
            A_STAT:    bus_rdata = {flags, {(BYTE_W-N_FLAGS){1'b0}}};
            A_CNT_HI:  bus_rdata = pick_byte(cnt_q, 1'b1);
            A_CNT_LO:  bus_rdata = pick_byte(cnt_q, 1'b0);
            A_CMP_HI:  bus_rdata = pick_byte(cmp_q, 1'b1);
            A_CMP_LO:  bus_rdata = pick_byte(cmp_q, 1'b0);
            A_CAP1_HI: bus_rdata = pick_byte(cap_val[0], 1'b1);
            A_CAP1_LO: bus_rdata = pick_byte(cap_val[0], 1'b0);
            A_CAP2_HI: bus_rdata = pick_byte(cap_val[1], 1'b1);
            A_CAP2_LO: bus_rdata = pick_byte(cap_val[1], 1'b0);
            default:   bus_rdata = '0;
        endcase
    end

    a_r2_wrap_to_zero: assert property (@(posedge clk) disable iff (rst)
        (tick && cnt_q == '1) |=> (cnt_q == '0 && flags[F_OVF]));

    a_r3_latch_load: assert property (@(posedge clk) disable iff (rst)
        cmp_ev |=> (out_latch == $past(ctrl_q.olvl) && flags[F_CMP]));

    a_r4_pin_gates_cap1: assert property (@(posedge clk) disable iff (rst)
        ctrl_q.pin_cmp |-> !cap_evt[0]);

    a_r10_irq_same_cycle: assert property (@(posedge clk) disable iff (rst)
        ($rose(flags[F_CAP2]) && ctrl_q.ie_cap2) |-> irq);

    a_r5_mode_keeps_flags: assert property (@(posedge clk) disable iff (rst)
        (flags[F_CAP1] && !stat_rd && !clr_vec[F_CAP1]) |=> flags[F_CAP1]);

endmodule

// File: tb/dcct_timer_test.sv
module dcct_timer_test;
    localparam int CLK_PERIOD = 10;
    localparam logic [1:0] OP_RD = 2'd0, OP_WR = 2'd1, OP_TK = 2'd2, OP_PN = 2'd3;
    localparam int NV = 36;
    // fields: op[29:28] addr[27:24] data[23:16] expect[15:8] req[7:0]
    // OP_PN expect bits: [2]=irq [1]=pin_oe [0]=pin_out
    localparam logic [29:0] VEC [0:NV-1] = '{
        {OP_RD, 4'd0, 8'h00, 8'h00, 8'd1},   // R1 control
        {OP_RD, 4'd1, 8'h00, 8'h00, 8'd1},   // R1 status
        {OP_PN, 4'd0, 8'h00, 8'h00, 8'd1},   // R1 pins, irq
        {OP_WR, 4'd4, 8'h00, 8'h00, 8'd3},
        {OP_WR, 4'd5, 8'h05, 8'h00, 8'd3},
        {OP_WR, 4'd0, 8'h11, 8'h00, 8'd3},
        {OP_TK, 4'd0, 8'd4,  8'h00, 8'd2},   // cnt 4
        {OP_RD, 4'd1, 8'h00, 8'h00, 8'd3},   // R3 no match yet
        {OP_TK, 4'd0, 8'd1,  8'h00, 8'd2},   // cnt 5 match
        {OP_PN, 4'd0, 8'h00, 8'h04, 8'd10},  // R10 irq, R4 pin off
        {OP_RD, 4'd1, 8'h00, 8'h10, 8'd3},   // R3 flag
        {OP_RD, 4'd3, 8'h00, 8'h05, 8'd2},   // R2 count
        {OP_WR, 4'd5, 8'h05, 8'h00, 8'd8},
        {OP_RD, 4'd1, 8'h00, 8'h00, 8'd8},   // R8 cleared
        {OP_PN, 4'd0, 8'h00, 8'h00, 8'd10},
        {OP_WR, 4'd0, 8'h18, 8'h00, 8'd4},
        {OP_PN, 4'd0, 8'h00, 8'h03, 8'd4},   // R4 latch=1 driven
        {OP_WR, 4'd5, 8'h07, 8'h00, 8'd3},
        {OP_TK, 4'd0, 8'd2,  8'h00, 8'd2},   // cnt 7 match, olvl 0
        {OP_PN, 4'd0, 8'h00, 8'h06, 8'd5},   // R5 flag in pin mode, latch 0
        {OP_RD, 4'd1, 8'h00, 8'h10, 8'd5},
        {OP_WR, 4'd5, 8'h07, 8'h00, 8'd8},
        {OP_RD, 4'd1, 8'h00, 8'h00, 8'd8},
        {OP_WR, 4'd0, 8'h08, 8'h00, 8'd10},
        {OP_WR, 4'd5, 8'h0A, 8'h00, 8'd3},
        {OP_TK, 4'd0, 8'd3,  8'h00, 8'd2},   // cnt 10 match
        {OP_PN, 4'd0, 8'h00, 8'h02, 8'd10},  // R10 masked
        {OP_WR, 4'd5, 8'h0A, 8'h00, 8'd8},   // access without status read
        {OP_RD, 4'd1, 8'h00, 8'h10, 8'd8},   // R8 still set
        {OP_RD, 4'd5, 8'h00, 8'h0A, 8'd8},   // read must not clear
        {OP_RD, 4'd1, 8'h00, 8'h10, 8'd8},
        {OP_WR, 4'd5, 8'h0A, 8'h00, 8'd8},
        {OP_RD, 4'd1, 8'h00, 8'h00, 8'd8},
        {OP_RD, 4'd4, 8'h00, 8'h00, 8'd3},
        {OP_RD, 4'd2, 8'h00, 8'h00, 8'd2},
        {OP_RD, 4'd3, 8'h00, 8'h0A, 8'd2}
    };

    logic       clk = 1'b0, rst = 1'b1, tick = 1'b0;
    logic [3:0] bus_addr = '0;
    logic       bus_rd = 1'b0, bus_wr = 1'b0;
    logic [7:0] bus_wdata = '0, bus_rdata;
    logic       pin_in = 1'b0, pin_out, pin_oe, cap2_in = 1'b0, irq;
    logic [15:0] mcnt;
    int checks = 0, fails = 0;
    bit done = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    dcct_timer uut (
        .clk(clk), .rst(rst), .tick(tick), .bus_addr(bus_addr),
        .bus_rd(bus_rd), .bus_wr(bus_wr), .bus_wdata(bus_wdata),
        .bus_rdata(bus_rdata), .pin_in(pin_in), .pin_out(pin_out),
        .pin_oe(pin_oe), .cap2_in(cap2_in), .irq(irq)
    );

    // reference count of applied ticks
    always @(posedge clk) begin
        if (rst) mcnt <= '0;
        else if (tick) mcnt <= mcnt + 16'd1;
    end

    task automatic check(input int req, input logic [7:0] got, input logic [7:0] exp,
                         input string what);
        checks++;
        if (got !== exp) begin
            fails++;
            $display("FAIL R%0d %s: got %02h expected %02h", req, what, got, exp);
        end
    endtask

    task automatic wr(input logic [3:0] a, input logic [7:0] d);
        @(negedge clk); bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
        @(negedge clk); bus_wr = 1'b0;
    endtask

    task automatic rd(input int req, input logic [3:0] a, input logic [7:0] exp);
        @(negedge clk); bus_addr = a; bus_rd = 1'b1;
        #1 check(req, bus_rdata, exp, $sformatf("read addr %0d", a));
        @(negedge clk); bus_rd = 1'b0;
    endtask

    task automatic pins(input int req, input logic [2:0] exp);
        @(negedge clk);
        #1 check(req, {5'd0, irq, pin_oe, pin_out}, {5'd0, exp}, "irq/oe/out");
    endtask

    task automatic ticks(input int n);
        @(negedge clk); tick = 1'b1;
        repeat (n) @(negedge clk);
        tick = 1'b0;
    endtask

    task automatic settle();
        repeat (4) @(negedge clk);
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1'b1;
            $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
            $finish;
        end
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        checks++; fails++;
        $display("FAIL watchdog: run did not complete");
        finish_run();
    end

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;

        for (int i = 0; i < NV; i++) begin
            case (VEC[i][29:28])
                OP_RD: rd(int'(VEC[i][7:0]), VEC[i][27:24], VEC[i][15:8]);
                OP_WR: wr(VEC[i][27:24], VEC[i][23:16]);
                OP_TK: ticks(int'(VEC[i][23:16]));
                default: pins(int'(VEC[i][7:0]), VEC[i][10:8]);
            endcase
        end

        // R7 capture 1 rising at count 10
        wr(4'd0, 8'h06);
        pin_in = 1'b1; settle();
        rd(7, 4'd1, 8'h40);
        rd(7, 4'd6, mcnt[15:8]);
        rd(7, 4'd7, mcnt[7:0]);
        rd(8, 4'd1, 8'h00);
        // R7 capture 2 rising
        ticks(3);
        cap2_in = 1'b1; settle();
        rd(7, 4'd1, 8'h80);
        rd(7, 4'd8, mcnt[15:8]);
        rd(7, 4'd9, mcnt[7:0]);
        rd(8, 4'd1, 8'h00);
        // R6 falling edges ignored under rising select
        ticks(2);
        pin_in = 1'b0; settle();
        rd(6, 4'd1, 8'h00);
        cap2_in = 1'b0; settle();
        rd(6, 4'd1, 8'h00);
        // R6 falling select: rising ignored, falling captured
        wr(4'd0, 8'h00);
        pin_in = 1'b1; settle();
        rd(6, 4'd1, 8'h00);
        pin_in = 1'b0; settle();
        rd(6, 4'd1, 8'h40);
        rd(6, 4'd7, mcnt[7:0]);
        rd(6, 4'd1, 8'h00);
        // R4 pin mode blocks capture 1 edges
        ticks(2);
        wr(4'd0, 8'h0C);
        pin_in = 1'b1; settle();
        rd(4, 4'd1, 8'h00);
        pin_in = 1'b0; settle();
        // R5 mode change keeps a set capture-1 flag
        wr(4'd0, 8'h04);
        pin_in = 1'b1; settle();
        rd(5, 4'd1, 8'h40);
        wr(4'd0, 8'h0C);
        rd(5, 4'd1, 8'h40);
        wr(4'd0, 8'h04);
        rd(5, 4'd7, mcnt[7:0]);
        rd(5, 4'd1, 8'h00);
        // R9 event between status read and data read
        wr(4'd0, 8'h02);
        cap2_in = 1'b1; settle();
        rd(9, 4'd1, 8'h80);
        ticks(3);
        cap2_in = 1'b0; settle();
        cap2_in = 1'b1; settle();
        rd(9, 4'd9, mcnt[7:0]);
        rd(9, 4'd1, 8'h80);
        rd(9, 4'd9, mcnt[7:0]);
        rd(9, 4'd1, 8'h00);
        // R2 wrap and overflow flag, R10 its interrupt
        wr(4'd0, 8'h20);
        ticks(65535 - int'(mcnt));
        rd(2, 4'd2, 8'hFF);
        rd(2, 4'd1, 8'h00);
        pins(10, 3'b000);
        ticks(1);
        pins(10, 3'b100);
        rd(2, 4'd1, 8'h20);
        rd(2, 4'd3, 8'h00);
        rd(8, 4'd1, 8'h00);
        pins(10, 3'b000);

        finish_run();
    end
endmodule